// File: doc/BRIEF.md
# Flash page-program write buffer

This block stages page-program data for a serial NOR flash and then writes it with one command. Software packs bytes four at a time into a 32-bit fill port, sets the target address in four byte-wide address registers, and writes a command code. The controller then runs the whole flash sequence on its own: a write-enable frame, a page-program frame carrying the opcode, the address and the buffered bytes, and repeated status-read frames until the flash reports that its write is finished. The command register reads back the running command until then, so software polls it.

The buffer is shared with a read-prefetch function. A mode bit picks which use owns it, and its readback shows the mode in effect. A change requested while a sequence runs is held back until the sequence ends. For tails shorter than a full page there is a one-byte path. It runs the same sequence with a single data byte and then advances the address by one, so a run of bytes needs no address reload.

Top module: `nor_pp_wbuf`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and both the command readback (offset 0x00) and the mode readback (offset 0x64) are 0.
- R2: Bit 0 of offset 0x64 requests the buffer mode: 0 means read prefetch, 1 means page program. The readback of that bit is the mode in effect. A request written while a sequence runs takes effect only after the sequence ends.
- R3: In program mode while idle, successive writes to offset 0x98 fill buffer words 0, 1, 2 and so on. Buffer byte 4n+j is bits 8j+7:8j of word n, so the lowest-addressed byte sits in bits 7:0. The buffer bytes go out on the wire in ascending byte order.
- R4: Writing 0x10 to offset 0x00 while idle in program mode sends frame [0x06], then frame [0x02, address bytes most significant first, all buffer bytes]. The number of address bytes is ADDR_BYTES. Address bytes 0, 1, 2 and 3 are held at offsets 0x10, 0x14, 0x18 and 0xC8. The command readback is 0x10 until the sequence ends and 0 afterwards.
- R5: After the program frame, the block sends status frames [0x05, one received byte]. It repeats them until the received bit 0 is 0, and only then returns to idle.
- R6: Writing 0x90 to offset 0x00 while idle runs the same sequence with one data byte, taken from bits 7:0 of offset 0x1C. The command readback is 0x90 while it runs. The 32-bit address then increases by one, which is visible at the address offsets.
- R7: Writing 0x10 in prefetch mode starts nothing. A fill-port write made in prefetch mode, or while a sequence runs, leaves the buffer unchanged. Address and command writes made while a sequence runs are ignored.
- R8: The fill position returns to word 0 when a buffered program sequence ends and whenever the mode in effect changes.
- R9: The serial clock idles low and stays low whenever `spi_cs_n` is 1. Each high phase of the clock lasts one clock cycle. Bits go out most significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, half the system clock rate while shifting |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A register write from software can land in the same cycle as the serial sequence is running. Fill-port words, address bytes, a second command and a mode change can all collide with a program that is already on the wire. The bench issues each of these writes right after it starts a buffered program. It then judges them at the ports: the next program frame must carry the old buffer bytes, the address readback must be unchanged, and the mode readback must hold its old value until the command readback drops to 0 and take the new value after. The status-poll loop is stressed by having the flash model report busy for zero to three polls while the frame counts are compared.

// File: rtl/nor_pp_pkg.sv
package nor_pp_pkg;

   // register byte offsets seen by software
   localparam logic [7:0] REG_CMD   = 8'h00;
   localparam logic [7:0] REG_ADR0  = 8'h10;
   localparam logic [7:0] REG_ADR1  = 8'h14;
   localparam logic [7:0] REG_ADR2  = 8'h18;
   localparam logic [7:0] REG_ADR3  = 8'hC8;
   localparam logic [7:0] REG_ONE   = 8'h1C;
   localparam logic [7:0] REG_MODE  = 8'h64;
   localparam logic [7:0] REG_FILL  = 8'h98;

   // command codes written to REG_CMD
   localparam logic [7:0] CMD_BUF   = 8'h10;
   localparam logic [7:0] CMD_ONE   = 8'h90;

   // flash opcodes
   localparam logic [7:0] OP_WREN   = 8'h06;
   localparam logic [7:0] OP_PROG   = 8'h02;
   localparam logic [7:0] OP_RDSR   = 8'h05;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WREN,
      ST_GAP_A,
      ST_PROG,
      ST_GAP_B,
      ST_POLL,
      ST_GAP_C
   } seq_state_e;

endpackage

// File: rtl/nor_pp_shifter.sv
// Serial engine, mode 0: shifts one word out on mosi and one word in from miso.
module nor_pp_shifter #(
   parameter int WIDTH = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] tx,
   input  logic             miso,
   output logic             sclk,
   output logic             mosi,
   output logic             active,
   output logic             done,
   output logic [WIDTH-1:0] rx
);
   localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("nor_pp_shifter: WIDTH must be at least 2");
   end

   logic [CNT_W-1:0] bitn;
   logic             ph;
   logic [WIDTH-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ph     <= 1'b0;
         sclk   <= 1'b0;
         bitn   <= '0;
         sh     <= '0;
         rx     <= '0;
      end else if (!active) begin
         sclk <= 1'b0;
         if (start) begin
            active <= 1'b1;
            sh     <= tx;
            bitn   <= CNT_W'(WIDTH - 1);
            ph     <= 1'b0;
         end
      end else if (!ph) begin
         // rising edge: capture the bit the flash set up on the last fall
         ph   <= 1'b1;
         sclk <= 1'b1;
         rx   <= {rx[WIDTH-2:0], miso};
      end else begin
         ph   <= 1'b0;
         sclk <= 1'b0;
         sh   <= {sh[WIDTH-2:0], 1'b0};
         if (bitn == '0) active <= 1'b0;
         else            bitn   <= bitn - 1'b1;
      end
   end

   assign mosi = sh[WIDTH-1];
   assign done = active & ph & (bitn == '0);

endmodule

// File: rtl/nor_pp_pagebuf.sv
// Page buffer: word-wide fill with an auto-advancing pointer, byte-wide read.
module nor_pp_pagebuf #(
   parameter int BUF_BYTES = 128,
   localparam int WORDS    = BUF_BYTES / 4,
   localparam int PTR_W    = $clog2(WORDS),
   localparam int BIDX_W   = $clog2(BUF_BYTES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [31:0]       wdata,
   input  logic [BIDX_W-1:0] rd_idx,
   output logic [7:0]        rd_byte,
   output logic [PTR_W-1:0]  fill_ptr
);
   if (BUF_BYTES < 8 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_size
      $error("nor_pp_pagebuf: BUF_BYTES must be a power of two of at least 8");
   end

   logic [WORDS-1:0][31:0] mem;
   logic [31:0]            rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem      <= '0;
         fill_ptr <= '0;
      end else begin
         if (we) mem[fill_ptr] <= wdata;
         if (clr)     fill_ptr <= '0;
         else if (we) fill_ptr <= fill_ptr + 1'b1;
      end
   end

   assign rd_word = mem[rd_idx[BIDX_W-1:2]];
   assign rd_byte = rd_word[8*rd_idx[1:0] +: 8];

endmodule

// File: rtl/nor_pp_wbuf.sv
module nor_pp_wbuf
   import nor_pp_pkg::*;
#(
   parameter int BUF_BYTES  = 128,
   parameter int ADDR_BYTES = 3
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        spi_cs_n,
   output logic        spi_sclk,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int WORDS  = BUF_BYTES / 4;
   localparam int PTR_W  = $clog2(WORDS);
   localparam int BIDX_W = $clog2(BUF_BYTES);
   localparam int IDX_W  = $clog2(ADDR_BYTES + BUF_BYTES + 2);

   if (ADDR_BYTES != 3 && ADDR_BYTES != 4) begin : g_bad_addr
      $error("nor_pp_wbuf: ADDR_BYTES must be 3 or 4");
   end

   seq_state_e       st;
   logic             single_q, wip_q, mode_req, mode_eff;
   logic [31:0]      addr_q;
   logic [7:0]       wbyte_q;
   logic [IDX_W-1:0] idx, didx, last_idx;
   logic             busy, shifting, wr_cmd, start_buf, start_one, fill_we, ptr_clr;
   logic [7:0]       tx_byte, buf_byte, eng_rx;
   logic             eng_act, eng_done, eng_start;
   logic [PTR_W-1:0] fill_ptr;

   assign busy      = (st != ST_IDLE);
   assign shifting  = (st == ST_WREN) || (st == ST_PROG) || (st == ST_POLL);
   assign wr_cmd    = bus_we && (bus_addr == REG_CMD) && !busy;
   assign start_buf = wr_cmd && (bus_wdata[7:0] == CMD_BUF) && mode_eff;
   assign start_one = wr_cmd && (bus_wdata[7:0] == CMD_ONE);
   assign fill_we   = bus_we && (bus_addr == REG_FILL) && !busy && mode_eff;
   assign ptr_clr   = ((st == ST_GAP_C) && !wip_q && !single_q) ||
                      (!busy && (mode_eff != mode_req));
   assign eng_start = shifting && !eng_act;
   assign spi_cs_n  = !shifting;
   assign last_idx  = single_q ? IDX_W'(ADDR_BYTES + 1) : IDX_W'(ADDR_BYTES + BUF_BYTES);
   assign didx      = idx - IDX_W'(ADDR_BYTES + 1);

   nor_pp_pagebuf #(.BUF_BYTES(BUF_BYTES)) pagebuf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ptr_clr),
      .we       (fill_we),
      .wdata    (bus_wdata),
      .rd_idx   (didx[BIDX_W-1:0]),
      .rd_byte  (buf_byte),
      .fill_ptr (fill_ptr)
   );

   nor_pp_shifter #(.WIDTH(8)) shifter_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (eng_start),
      .tx     (tx_byte),
      .miso   (spi_miso),
      .sclk   (spi_sclk),
      .mosi   (spi_mosi),
      .active (eng_act),
      .done   (eng_done),
      .rx     (eng_rx)
   );

   // byte to shift for the current frame position
   always_comb begin
      tx_byte = 8'h00;
      case (st)
         ST_WREN: tx_byte = OP_WREN;
         ST_POLL: tx_byte = (idx == '0) ? OP_RDSR : 8'h00;
         ST_PROG: begin
            if (idx == '0)
               tx_byte = OP_PROG;
            else if (idx > IDX_W'(ADDR_BYTES))
               tx_byte = single_q ? wbyte_q : buf_byte;
            else
               for (int k = 1; k <= ADDR_BYTES; k++)
                  if (idx == IDX_W'(k)) tx_byte = addr_q[8*(ADDR_BYTES-k) +: 8];
         end
         default: tx_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         single_q <= 1'b0;
         wip_q    <= 1'b0;
         mode_req <= 1'b0;
         mode_eff <= 1'b0;
         addr_q   <= '0;
         wbyte_q  <= '0;
         idx      <= '0;
      end else begin
         if (bus_we && bus_addr == REG_MODE) mode_req <= bus_wdata[0];
         if (!busy) mode_eff <= mode_req;
         if (bus_we && !busy) begin
            case (bus_addr)
               REG_ADR0: addr_q[7:0]   <= bus_wdata[7:0];
               REG_ADR1: addr_q[15:8]  <= bus_wdata[7:0];
               REG_ADR2: addr_q[23:16] <= bus_wdata[7:0];
               REG_ADR3: addr_q[31:24] <= bus_wdata[7:0];
               REG_ONE:  wbyte_q       <= bus_wdata[7:0];
               default: ;
            endcase
         end
         case (st)
            ST_IDLE: if (start_buf || start_one) begin
               single_q <= start_one;
               idx      <= '0;
               st       <= ST_WREN;
            end
            ST_WREN: if (eng_done) st <= ST_GAP_A;
            ST_GAP_A: begin
               idx <= '0;
               st  <= ST_PROG;
            end
            ST_PROG: if (eng_done) begin
               if (idx == last_idx) st  <= ST_GAP_B;
               else                 idx <= idx + 1'b1;
            end
            ST_GAP_B: begin
               idx <= '0;
               st  <= ST_POLL;
            end
            ST_POLL: if (eng_done) begin
               if (idx == '0) idx <= IDX_W'(1);
               else begin
                  wip_q <= eng_rx[0];
                  st    <= ST_GAP_C;
               end
            end
            ST_GAP_C: begin
               idx <= '0;
               if (wip_q) st <= ST_POLL;
               else begin
                  st <= ST_IDLE;
                  if (single_q) addr_q <= addr_q + 32'd1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         REG_CMD:  bus_rdata = busy ? {24'h0, (single_q ? CMD_ONE : CMD_BUF)} : 32'h0;
         REG_ADR0: bus_rdata = {24'h0, addr_q[7:0]};
         REG_ADR1: bus_rdata = {24'h0, addr_q[15:8]};
         REG_ADR2: bus_rdata = {24'h0, addr_q[23:16]};
         REG_ADR3: bus_rdata = {24'h0, addr_q[31:24]};
         REG_ONE:  bus_rdata = {24'h0, wbyte_q};
         REG_MODE: bus_rdata = {31'h0, mode_eff};
         default:  bus_rdata = 32'h0;
      endcase
   end

endmodule

// File: rtl/nor_pp_wbuf_chk.sv
module nor_pp_wbuf_chk #(
   parameter int PTR_W = 5
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             sclk,
   input logic             busy,
   input logic             mode_eff,
   input logic [PTR_W-1:0] fill_ptr,
   input logic             single,
   input logic [31:0]      addr
);
   // R9
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R9
   sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |=> !sclk);

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (mode_eff == $past(mode_eff)));

   // R7
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(fill_ptr));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(addr));

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && single) |-> (addr == $past(addr) + 32'd1));

endmodule

bind nor_pp_wbuf nor_pp_wbuf_chk #(.PTR_W(PTR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (spi_cs_n),
   .sclk     (spi_sclk),
   .busy     (busy),
   .mode_eff (mode_eff),
   .fill_ptr (fill_ptr),
   .single   (single_q),
   .addr     (addr_q)
);

// File: tb/nor_pp_wbuf_tb_top.sv
module nor_pp_wbuf_tb_top;
   localparam int BUF = 16;
   localparam int AB  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h0;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic        cs_n, sclk, mosi;
   logic        miso = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   nor_pp_wbuf #(.BUF_BYTES(BUF), .ADDR_BYTES(AB)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(rdata), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso)
   );

   int checks = 0;
   int fails  = 0;
   int viol   = 0;

   // ---------------- flash model: records frames, answers status reads
   logic [7:0] fb [0:15][0:23];
   int         flen [0:15];
   int         nfr = 0;
   int         bitc = 0;
   int         polls_busy = 0;
   logic [7:0] shin = 8'h0;

   always @(negedge cs_n) begin
      bitc = 0;
      if (nfr < 16) flen[nfr] = 0;
   end

   always @(posedge sclk) begin
      if (!cs_n) begin
         shin = {shin[6:0], mosi};
         bitc = bitc + 1;
         if ((bitc % 8) == 0 && nfr < 16 && (bitc / 8) <= 24) begin
            fb[nfr][bitc/8 - 1] = shin;
            flen[nfr] = bitc / 8;
         end
      end
   end

   always @(posedge cs_n) begin
      if (nfr < 16) begin
         if (flen[nfr] > 0 && fb[nfr][0] == 8'h05 && polls_busy > 0)
            polls_busy = polls_busy - 1;
         nfr = nfr + 1;
      end
   end

   always @(negedge sclk) begin
      if (!cs_n && bitc >= 8 && bitc < 16 && nfr < 16 && fb[nfr][0] == 8'h05)
         miso <= (polls_busy > 0) && (bitc == 15);
      else
         miso <= 1'b0;
   end

   // R9 monitor: clock high for exactly one cycle, low while deselected
   logic prev_sclk = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_sclk && sclk) viol++;
         if (cs_n && sclk) viol++;
      end
      prev_sclk = sclk;
   end

   // ---------------- helpers
   logic [7:0] exp_buf [0:BUF-1];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         rd(8'h00, v);
         if (v == 32'h0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int k, input int i);
      return 8'((k * 37 + i * 11) ^ 8'h5A);
   endfunction

   task automatic fill_word(input int w, input logic [31:0] d);
      wr(8'h98, d);
      for (int j = 0; j < 4; j++) exp_buf[4*w + j] = d[8*j +: 8];
   endtask

   task automatic fill_all(input int k);
      for (int w = 0; w < BUF/4; w++)
         fill_word(w, {pat(k, 4*w+3), pat(k, 4*w+2), pat(k, 4*w+1), pat(k, 4*w)});
   endtask

   task automatic clear_log(input int busy_polls);
      nfr = 0;
      polls_busy = busy_polls;
   endtask

   task automatic set_addr(input logic [23:0] a);
      wr(8'h10, {24'h0, a[7:0]});
      wr(8'h14, {24'h0, a[15:8]});
      wr(8'h18, {24'h0, a[23:16]});
   endtask

   task automatic verify(input string tag, input logic [23:0] a, input int nd, input int npoll);
      int bad;
      chk({tag, " R5 frame count"}, 32'(nfr), 32'(2 + npoll));
      chk({tag, " R4 write-enable frame"}, {24'(flen[0]), fb[0][0]}, {24'd1, 8'h06});
      chk({tag, " R4 program header"}, {fb[1][0], fb[1][1], fb[1][2], fb[1][3]},
          {8'h02, a[23:16], a[15:8], a[7:0]});
      chk({tag, " R4 program length"}, 32'(flen[1]), 32'(1 + AB + nd));
      bad = 0;
      for (int i = 0; i < nd; i++) if (fb[1][1 + AB + i] !== exp_buf[i]) bad++;
      chk({tag, " R3 data bytes in order"}, 32'(bad), 32'd0);
      bad = 0;
      for (int p = 0; p < npoll; p++)
         if (flen[2+p] != 2 || fb[2+p][0] != 8'h05) bad++;
      chk({tag, " R5 status frames"}, 32'(bad), 32'd0);
   endtask

   task automatic finish_run();
      chk("R9 serial clock shape violations", 32'(viol), 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // ---------------- main sequence
   initial begin
      logic [31:0] v;
      for (int i = 0; i < BUF; i++) exp_buf[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, v); chk("R1 command readback", v, 32'h0);
      rd(8'h64, v); chk("R1 mode readback", v, 32'h0);
      chk("R1 chip select idle", {31'h0, cs_n}, 32'h1);
      chk("R1 serial clock idle", {31'h0, sclk}, 32'h0);

      // R2 switch to program mode
      wr(8'h64, 32'h1);
      rd(8'h64, v); chk("R2 mode becomes program", v, 32'h1);

      // buffered program with colliding writes
      set_addr(24'h123456);
      fill_all(0);
      clear_log(2);
      wr(8'h00, 32'h10);
      rd(8'h00, v); chk("R4 command readback while busy", v, 32'h10);
      wr(8'h98, 32'hDEADBEEF);   // R7 ignored
      wr(8'h10, 32'h99);         // R7 ignored
      wr(8'h00, 32'h90);         // R7 ignored
      wr(8'h64, 32'h0);
      rd(8'h64, v); chk("R2 mode held while busy", v, 32'h1);
      rd(8'h00, v); chk("R7 second command ignored", v, 32'h10);
      wait_idle();
      verify("prog0", 24'h123456, BUF, 3);
      rd(8'h64, v); chk("R2 deferred mode applied", v, 32'h0);
      rd(8'h10, v); chk("R7 address write while busy ignored", v, 32'h56);
      rd(8'h00, v); chk("R4 command readback after done", v, 32'h0);

      // R7 prefetch mode: fill and program ignored
      wr(8'h98, 32'h11111111);
      clear_log(0);
      wr(8'h00, 32'h10);
      rd(8'h00, v); chk("R7 program in prefetch mode ignored", v, 32'h0);
      repeat (60) @(negedge clk);
      chk("R7 no frames in prefetch mode", 32'(nfr), 32'd0);

      // buffer contents survived ignored writes
      wr(8'h64, 32'h1);
      clear_log(0);
      wr(8'h00, 32'h10);
      wait_idle();
      verify("R7 reuse", 24'h123456, BUF, 1);

      // R8 pointer back at word 0 after a program
      fill_word(0, 32'hA1B2C3D4);
      clear_log(1);
      wr(8'h00, 32'h10);
      wait_idle();
      verify("R8 after program", 24'h123456, BUF, 2);

      // R8 pointer back at word 0 after a mode change
      fill_word(0, 32'h01020304);
      wr(8'h64, 32'h0);
      wr(8'h64, 32'h1);
      rd(8'h64, v); chk("R2 mode back to program", v, 32'h1);
      fill_word(0, 32'hCAFEF00D);
      clear_log(0);
      wr(8'h00, 32'h10);
      wait_idle();
      verify("R8 after mode change", 24'h123456, BUF, 1);

      // sweep of patterns, addresses and busy poll counts (R3, R5)
      for (int k = 1; k <= 6; k++) begin
         logic [23:0] a;
         a = 24'(k * 24'h010203 + 24'h0000F0);
         set_addr(a);
         fill_all(k);
         clear_log(k % 4);
         wr(8'h00, 32'h10);
         wait_idle();
         verify($sformatf("R3 sweep %0d", k), a, BUF, (k % 4) + 1);
      end

      // R6 single-byte path with address increment
      wr(8'h64, 32'h0);
      set_addr(24'h0000FF);
      wr(8'h1C, 32'hA5);
      exp_buf[0] = 8'hA5;
      clear_log(1);
      wr(8'h00, 32'h90);
      rd(8'h00, v); chk("R6 command readback while busy", v, 32'h90);
      wait_idle();
      verify("R6 first byte", 24'h0000FF, 1, 2);
      wr(8'h1C, 32'h3C);
      exp_buf[0] = 8'h3C;
      clear_log(0);
      wr(8'h00, 32'h90);
      wait_idle();
      verify("R6 second byte", 24'h000100, 1, 1);
      rd(8'h10, v); chk("R6 address byte 0 advanced", v, 32'h01);
      rd(8'h14, v); chk("R6 address byte 1 advanced", v, 32'h01);

      // R6 sweep of single bytes in program mode too
      wr(8'h64, 32'h1);
      for (int k = 0; k < 4; k++) begin
         wr(8'h1C, {24'h0, pat(9, k)});
         exp_buf[0] = pat(9, k);
         clear_log(0);
         wr(8'h00, 32'h90);
         wait_idle();
         verify($sformatf("R6 single sweep %0d", k), 24'(24'h000101 + k), 1, 1);
      end

      finish_run();
   end

endmodule